// File: doc/BRIEF.md
# Exception Vectoring and Context Capture Unit

This unit sits beside a processor pipeline and turns exception requests into a fetch redirect. It collects single-cycle request pulses from six sources into a pending set. Each cycle it picks the most urgent eligible source and forms the handler address from a vector base and a fixed per-source offset. In the same step it saves the return context. It keeps a three-bit machine state word with a vector-base select bit, an external-enable bit and a recoverable bit. It also keeps two save registers: one for the return address and one for the prior state word.

A return-from-interrupt strobe restores the state word and sends fetch back to the saved address. A small write port lets software update the state word, for example to set the recoverable bit once it has stacked the save registers. If an exception arrives while that bit is clear, the context would be lost, so the exception is turned into a machine check. A configuration input decides whether a machine check runs its handler or freezes the unit in a checkstop. The redirect is a plain one-cycle strobe with no back-pressure: the pipeline must accept it in the cycle it appears.

Top module: `exc_vector_unit`

## Requirements
- R1: A taken exception redirects to base OR offset. The base is 0x00000000 when state bit IP is 0 and 0xFFF00000 when IP is 1. The offsets are: soft reset 0x100, machine check 0x200, data access fault 0x300, instruction access fault 0x400, external interrupt 0x500, decrementer 0x900. A request pulse seen at one rising edge gives a redirect strobe after the next rising edge.
- R2: While rst_n is low, the unit samples cfg_prefix into IP and clears EE and RI, redirect_valid and checkstop. At the first rising edge after release it redirects to the reset vector.
- R3: When several requests are pending, the one taken first is, in order: reset, machine check, data access fault, instruction access fault, external interrupt, decrementer.
- R4: While EE is 0, external interrupt and decrementer requests stay pending and are not taken. They are taken at the edge after the one that sets EE to 1. The other sources ignore EE.
- R5: On entry, srr0 receives nia and srr1 receives the prior state word. The state word is packed as bit 2 IP, bit 1 EE, bit 0 RI.
- R6: On entry, EE and RI are cleared and IP is kept.
- R7: A non-reset exception taken while RI is 0 is handled as a machine check.
- R8: A machine check taken with cfg_mc_stop high sets checkstop and gives no redirect. Checkstop then holds until hard reset, and the unit ignores all requests, return strobes and state writes.
- R9: A soft reset request uses the current IP, not the cfg_prefix pin. It is never escalated, even when RI is 0.
- R10: A return strobe copies srr1 into the state word and redirects to srr0 after the next rising edge.
- R11: In a single cycle, taking an exception beats a return strobe, and a return strobe beats a state write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hard reset, active low |
| cfg_prefix | input | 1 | Vector-base select sampled during hard reset |
| cfg_mc_stop | input | 1 | 1: machine check forces checkstop |
| req_soft_rst | input | 1 | Soft reset request pulse |
| req_mchk | input | 1 | Machine check request pulse |
| req_dacc | input | 1 | Data access fault pulse |
| req_iacc | input | 1 | Instruction access fault pulse |
| req_ext | input | 1 | External interrupt pulse |
| req_dec | input | 1 | Decrementer pulse |
| nia | input | 32 | Address of next instruction |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_wr | input | 1 | State word write strobe |
| msr_wdata | input | 3 | State word write value {IP,EE,RI} |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | 32 | Fetch redirect address |
| checkstop | output | 1 | Checkstop state |
| msr_state | output | 3 | State word {IP,EE,RI} |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 3 | Saved prior state word |

## Verification
A request pulse set up before edge N is latched at N and arbitrated in the following cycle. Its redirect, state update and checkstop all show after edge N+1. A return strobe or state write shows one edge after it is driven. An external or decrementer request held back by EE shows one edge after the write that sets EE. The bench drives on falling edges and samples on the falling edge after the edge where each result is due. It also samples at the intermediate falling edges to confirm that held-back or ignored stimulus produced no redirect.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int SRC_N    = 6;
  localparam int SRC_RST  = 0;
  localparam int SRC_MCHK = 1;
  localparam int SRC_DACC = 2;
  localparam int SRC_IACC = 3;
  localparam int SRC_EXT  = 4;
  localparam int SRC_DEC  = 5;

  localparam int ST_W  = 3;
  localparam int ST_IP = 2;
  localparam int ST_EE = 1;
  localparam int ST_RI = 0;

  function automatic logic [11:0] vec_offset(input logic [2:0] idx);
    case (idx)
      3'd0:    vec_offset = 12'h100;
      3'd1:    vec_offset = 12'h200;
      3'd2:    vec_offset = 12'h300;
      3'd3:    vec_offset = 12'h400;
      3'd4:    vec_offset = 12'h500;
      3'd5:    vec_offset = 12'h900;
      default: vec_offset = 12'h100;
    endcase
  endfunction
endpackage

// File: rtl/exc_pend_arb.sv
module exc_pend_arb #(
  parameter int N = exc_vec_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ee,
  input  logic         hold,
  input  logic [N-1:0] clr,
  output logic [N-1:0] grant,
  output logic         grant_any
);
  logic [N-1:0] pend;
  logic [N-1:0] elig;

  // Hard reset leaves the reset source pending so the core starts at its vector.
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= N'(1);
    else        pend <= (pend & ~clr) | req;
  end

  for (genvar i = 0; i < N; i++) begin : g_elig
    localparam bit MASKABLE = (i == exc_vec_pkg::SRC_EXT) || (i == exc_vec_pkg::SRC_DEC);
    if (MASKABLE) begin : g_m
      assign elig[i] = pend[i] & ee & ~hold;
    end else begin : g_u
      assign elig[i] = pend[i] & ~hold;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign grant_any = |grant;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_MASK_BY_EE: assert property (@(posedge clk) disable iff (!rst_n)
    !ee |-> !grant[exc_vec_pkg::SRC_EXT] && !grant[exc_vec_pkg::SRC_DEC]); // R4
  AST_EXT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[exc_vec_pkg::SRC_EXT] && !clr[exc_vec_pkg::SRC_EXT]) |=> pend[exc_vec_pkg::SRC_EXT]); // R4
endmodule

// File: rtl/exc_ctx.sv
module exc_ctx #(
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_prefix,
  input  logic                        take,
  input  logic                        rfi_go,
  input  logic                        wr_go,
  input  logic [exc_vec_pkg::ST_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]           nia,
  output logic [exc_vec_pkg::ST_W-1:0] msr,
  output logic [ADDR_W-1:0]           srr0,
  output logic [exc_vec_pkg::ST_W-1:0] srr1
);
  import exc_vec_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr  <= {cfg_prefix, 1'b0, 1'b0};
      srr0 <= '0;
      srr1 <= '0;
    end else if (take) begin
      srr0       <= nia;
      srr1       <= msr;
      msr[ST_EE] <= 1'b0;
      msr[ST_RI] <= 1'b0;
    end else if (rfi_go) begin
      msr <= srr1;
    end else if (wr_go) begin
      msr <= wr_data;
    end
  end

  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (srr0 == $past(nia)) && (srr1 == $past(msr))); // R5
  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !msr[ST_EE] && !msr[ST_RI] && (msr[ST_IP] == $past(msr[ST_IP]))); // R6
  AST_RFI_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_go |=> msr == $past(srr1)); // R10
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit #(
  parameter int              ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_prefix,
  input  logic              cfg_mc_stop,
  input  logic              req_soft_rst,
  input  logic              req_mchk,
  input  logic              req_dacc,
  input  logic              req_iacc,
  input  logic              req_ext,
  input  logic              req_dec,
  input  logic [ADDR_W-1:0] nia,
  input  logic              rfi,
  input  logic              msr_wr,
  input  logic [2:0]        msr_wdata,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              checkstop,
  output logic [2:0]        msr_state,
  output logic [ADDR_W-1:0] srr0,
  output logic [2:0]        srr1
);
  import exc_vec_pkg::*;

  localparam int NSRC  = SRC_N;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]   req_vec, grant, clr;
  logic              grant_any, eff_mc, stop_now, take_ctx, rfi_go, wr_go;
  logic [IDX_W-1:0]  idx, eff_idx;
  logic [ADDR_W-1:0] vec_addr;
  logic [ST_W-1:0]   msr_q;

  assign req_vec = {req_dec, req_ext, req_iacc, req_dacc, req_mchk, req_soft_rst};

  exc_pend_arb #(.N(NSRC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_vec),
    .ee        (msr_q[ST_EE]),
    .hold      (checkstop),
    .clr       (clr),
    .grant     (grant),
    .grant_any (grant_any)
  );

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) idx = IDX_W'(i);
  end

  // Unrecoverable entry (RI clear) turns any non-reset source into a machine check.
  assign eff_mc   = grant[SRC_MCHK] | (grant_any & ~grant[SRC_RST] & ~msr_q[ST_RI]);
  assign eff_idx  = eff_mc ? IDX_W'(SRC_MCHK) : idx;
  assign stop_now = grant_any & eff_mc & cfg_mc_stop;
  assign take_ctx = grant_any & ~stop_now;
  assign clr      = grant_any ? grant : '0;
  assign rfi_go   = rfi & ~checkstop & ~grant_any;
  assign wr_go    = msr_wr & ~checkstop & ~grant_any & ~rfi;
  assign vec_addr = (msr_q[ST_IP] ? HI_BASE : '0) | ADDR_W'(vec_offset(3'(eff_idx)));

  exc_ctx #(.ADDR_W(ADDR_W)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_prefix (cfg_prefix),
    .take       (take_ctx),
    .rfi_go     (rfi_go),
    .wr_go      (wr_go),
    .wr_data    (msr_wdata),
    .nia        (nia),
    .msr        (msr_q),
    .srr0       (srr0),
    .srr1       (srr1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      checkstop   <= 1'b0;
    end else begin
      redir_valid <= 1'b0;
      if (stop_now) begin
        checkstop <= 1'b1;
      end else if (take_ctx) begin
        redir_valid <= 1'b1;
        redir_addr  <= vec_addr;
      end else if (rfi_go) begin
        redir_valid <= 1'b1;
        redir_addr  <= srr0;
      end
    end
  end

  assign msr_state = msr_q;

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take_ctx |=> redir_valid && (redir_addr[7:0] == 8'h00)); // R1
  AST_ESCALATE_MC: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_any && !grant[SRC_RST] && !msr_q[ST_RI] && !cfg_mc_stop)
      |=> redir_valid && (redir_addr[11:0] == 12'h200)); // R7
  AST_CHECKSTOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop && !redir_valid); // R8
  AST_CHECKSTOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> $stable(msr_state) && $stable(srr0)); // R8
endmodule

// File: tb/test_exc_vector_unit.sv
`timescale 1ns/1ps
module test_exc_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_prefix = 1'b0, cfg_mc_stop = 1'b0;
  logic [5:0]  req = '0;
  logic [31:0] nia = '0;
  logic        rfi = 1'b0, msr_wr = 1'b0;
  logic [2:0]  msr_wdata = '0;
  logic        redir_valid, checkstop;
  logic [31:0] redir_addr, srr0;
  logic [2:0]  msr_state, srr1;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  exc_vector_unit i_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .cfg_prefix(cfg_prefix), .cfg_mc_stop(cfg_mc_stop),
    .req_soft_rst(req[0]), .req_mchk(req[1]), .req_dacc(req[2]), .req_iacc(req[3]),
    .req_ext(req[4]), .req_dec(req[5]), .nia(nia), .rfi(rfi), .msr_wr(msr_wr),
    .msr_wdata(msr_wdata), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .checkstop(checkstop), .msr_state(msr_state), .srr0(srr0), .srr1(srr1)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input logic p, input int s);
    logic [31:0] off;
    off = (s < 5) ? 32'((s + 1) * 256) : 32'h900;
    return (p ? 32'hFFF0_0000 : 32'h0) | off;
  endfunction

  task automatic hreset(input logic p);
    @(negedge clk);
    rst_n = 1'b0; cfg_prefix = p; req = '0; rfi = 0; msr_wr = 0;
    repeat (3) @(negedge clk);
    check(!redir_valid && !checkstop, "R2 reset idle", {30'd0, redir_valid, checkstop}, 32'd0);
    check(msr_state == {p, 2'b00}, "R2 reset state", 32'(msr_state), 32'({p, 2'b00}));
    rst_n = 1'b1;
    @(negedge clk);
    check(redir_valid && redir_addr == exp_vec(p, 0), "R2 reset vector", redir_addr, exp_vec(p, 0));
    @(negedge clk);
  endtask

  task automatic write_state(input logic [2:0] v);
    msr_wr = 1'b1; msr_wdata = v;
    @(negedge clk);
    msr_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [5:0] m);
    req = m;
    @(negedge clk);
    req = '0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Sweep: prefix x source x EE x RI x stop-config
    for (int p = 0; p < 2; p++)
      for (int s = 1; s < 6; s++)
        for (int ee = 0; ee < 2; ee++)
          for (int ri = 0; ri < 2; ri++)
            for (int ms = 0; ms < 2; ms++) begin
              logic cur_ee;
              logic eff_mc;
              logic [31:0] a;
              hreset(p[0]);
              cfg_mc_stop = ms[0];
              write_state({p[0], ee[0], ri[0]});
              a = 32'h1000_0000 + 32'((p * 40 + s * 8 + ee * 4 + ri * 2 + ms) * 4);
              nia = a;
              cur_ee = ee[0];
              pulse_req(6'(1 << s));
              if (s >= 4 && ee == 0) begin
                check(!redir_valid, "R4 masked no redirect", 32'(redir_valid), 32'd0);
                @(negedge clk);
                check(!redir_valid, "R4 masked still pending", 32'(redir_valid), 32'd0);
                write_state({p[0], 1'b1, ri[0]});
                cur_ee = 1'b1;
                @(negedge clk);
              end
              eff_mc = (s == 1) || (ri == 0);
              if (eff_mc && ms == 1) begin
                check(checkstop && !redir_valid, "R8 checkstop entered", {30'd0, checkstop, redir_valid}, 32'd2);
                pulse_req(6'b000100);
                rfi = 1'b1; @(negedge clk); rfi = 1'b0;
                check(checkstop && !redir_valid, "R8 checkstop ignores input", {30'd0, checkstop, redir_valid}, 32'd2);
              end else begin
                check(redir_valid && redir_addr == exp_vec(p[0], eff_mc ? 1 : s),
                      eff_mc ? "R7 escalated vector" : "R1 vector address",
                      redir_addr, exp_vec(p[0], eff_mc ? 1 : s));
                check(srr0 == a && srr1 == {p[0], cur_ee, ri[0]}, "R5 context save",
                      srr0 ^ 32'(srr1), a ^ 32'({p[0], cur_ee, ri[0]}));
                check(msr_state == {p[0], 2'b00}, "R6 entry clears EE RI", 32'(msr_state), 32'({p[0], 2'b00}));
                rfi = 1'b1; @(negedge clk); rfi = 1'b0;
                check(redir_valid && redir_addr == a, "R10 return address", redir_addr, a);
                check(msr_state == {p[0], cur_ee, ri[0]}, "R10 state restore", 32'(msr_state), 32'({p[0], cur_ee, ri[0]}));
              end
            end

    // R3: every non-empty mix of the five non-reset sources
    cfg_mc_stop = 1'b0;
    for (int m = 1; m < 32; m++) begin
      int first;
      first = 0;
      for (int b = 4; b >= 0; b--) if (m[b]) first = b + 1;
      hreset(1'b0);
      write_state(3'b011);
      pulse_req(6'(m << 1));
      check(redir_valid && redir_addr == exp_vec(1'b0, first), "R3 priority", redir_addr, exp_vec(1'b0, first));
    end

    // R9: soft reset uses current IP, never escalated
    hreset(1'b1);
    write_state(3'b011);
    pulse_req(6'b000001);
    check(redir_valid && redir_addr == 32'h100, "R9 soft reset keeps IP", redir_addr, 32'h100);
    pulse_req(6'b000001);
    check(redir_valid && redir_addr == 32'h100, "R9 soft reset with RI clear", redir_addr, 32'h100);
    check(msr_state[2] == 1'b0, "R9 IP unchanged", 32'(msr_state[2]), 32'd0);

    // R11: exception over return, return over write
    hreset(1'b0);
    write_state(3'b011);
    nia = 32'h0000_4440;
    pulse_req(6'b000100);
    write_state(3'b011);
    req = 6'b001000; @(negedge clk); req = '0;
    rfi = 1'b1; @(negedge clk); rfi = 1'b0;
    check(redir_valid && redir_addr == 32'h400, "R11 exception beats return", redir_addr, 32'h400);
    rfi = 1'b1; msr_wr = 1'b1; msr_wdata = 3'b001;
    @(negedge clk);
    rfi = 1'b0; msr_wr = 1'b0;
    check(redir_valid && redir_addr == 32'h0000_4440, "R11 return beats write addr", redir_addr, 32'h0000_4440);
    check(msr_state == 3'b011, "R11 return beats write state", 32'(msr_state), 32'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule